// File: doc/BRIEF.md
# Event Timer with Deferred Comparator Update

This block is a free-running up-counter with one comparator channel behind a small word-addressed register bus. Software reads the counter, adds a delta, writes the sum as the new compare value and waits for an interrupt. The counter advances only in cycles where the `tick` enable pulse is high and the timer is enabled. The pulse stands in for the slower timer clock domain.

A compare write does not reach the live comparator at once. It is parked in a staging register and copied across on a later tick. Until then the old compare value stays in force, and a read of the compare register returns it. A status flag shows that a staged value is still waiting.

The match test is selectable. Equality mode fires only on an exact hit, so a value already in the past is missed until the counter wraps. Wrap-aware mode fires whenever the counter has reached or passed the compare value, judged by the sign of their difference.

Top module: `evt_timer`

## Requirements
- R1: The counter is `CNT_W` bits wide (default 32). It increments by one at each clock edge where `tick` is high and the enable bit is set, wraps from all-ones to zero, and holds its value in every other cycle.
- R2: The register map uses word addresses: 0 is the counter (read-only, writes ignored); 1 is compare; 2 is control (bit 0 enable, bit 1 wrap-aware mode, read back in the same bits); 3 is status (bit 0 event, bit 1 transfer pending). Unused bits read zero. Read data is combinational from `bus_addr`.
- R3: A write to address 1 loads only the staging register. The active comparator takes the staged value at the edge of the `XFER_TICKS`-th tick (1 or 2) counted strictly after the write cycle, whether or not the timer is enabled. A read of address 1 returns the active value, so a read right after a write returns the previous value.
- R4: Status bit 1 is high from the cycle after a compare write until the staged value has been transferred.
- R5: In equality mode, a tick with the timer enabled and counter equal to the active compare sets the event bit, which is visible in the next cycle. A compare value already passed gives no event until the counter wraps around to it.
- R6: In wrap-aware mode, a tick with the timer enabled sets the event bit when (counter − compare), taken as a signed `CNT_W`-bit value, is zero or positive. A passed value therefore fires on the first tick, and the event re-arms on every tick while the condition holds.
- R7: The event bit is sticky. Writing address 3 with bit 0 set clears it. Writing 0 leaves it unchanged. A new event in the same cycle as a clear leaves it set.
- R8: `irq` equals the event bit ANDed with the enable bit.
- R9: A synchronous active-high `rst` clears the counter, staging and active compare, control, pending flag and event bit.
- R10: With the enable bit clear, ticks neither advance the counter nor set the event bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-cycle timer tick enable |
| bus_addr | input | 2 | Register word address |
| bus_wen | input | 1 | Register write strobe |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request |

## Verification
The match function is driven with a table of start points and compare values on a narrow 8-bit instance:
- future targets, which both modes must reach after the same tick count;
- past targets, where equality mode waits for a full wrap and wrap-aware mode fires on the first tick;
- an exact hit on the current count;
- pairs that straddle the wrap point, where the signed difference has to be judged across zero.

Directed tests on the 32-bit default instance cover the posting window:
- the compare read-back stays stale for one and then two ticks;
- the pending flag tracks that window.

Further directed tests cover the sticky event with write-one-to-clear, including a clear that collides with a new event, gating of `irq` by the enable bit, and reset in the middle of operation.

// File: rtl/evt_pkg.sv
`timescale 1ns/1ps
package evt_pkg;

    typedef enum logic [1:0] {
        SEL_COUNT  = 2'd0,
        SEL_CMP    = 2'd1,
        SEL_CTRL   = 2'd2,
        SEL_STATUS = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic wrap;
        logic en;
    } ctrl_t;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_WRAP_BIT = 1;
    localparam int STAT_EVT_BIT  = 0;
    localparam int STAT_PEND_BIT = 1;

    function automatic ctrl_t ctrl_decode(input logic [1:0] bits);
        ctrl_t c;
        c.en   = bits[CTRL_EN_BIT];
        c.wrap = bits[CTRL_WRAP_BIT];
        return c;
    endfunction

endpackage

// File: rtl/evt_counter.sv
`timescale 1ns/1ps
module evt_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             adv,
    output logic [CNT_W-1:0] count
);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (adv) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/evt_cmp_stage.sv
`timescale 1ns/1ps
module evt_cmp_stage #(
    parameter int CNT_W      = 32,
    parameter int XFER_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             tick,
    output logic [CNT_W-1:0] active,
    output logic             pending
);

    logic [CNT_W-1:0] staged_q;
    logic             xfer;

    generate
        if (XFER_TICKS <= 1) begin : g_single
            assign xfer = pending && tick && !wr;
        end else begin : g_multi
            localparam int SW = $clog2(XFER_TICKS);
            logic [SW-1:0] seen_q;

            always_ff @(posedge clk) begin
                if (rst || wr) begin
                    seen_q <= '0;
                end else if (pending && tick) begin
                    seen_q <= seen_q + 1'b1;
                end
            end

            assign xfer = pending && tick && !wr
                          && (seen_q == SW'(XFER_TICKS - 1));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            staged_q <= '0;
        end else if (wr) begin
            staged_q <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else if (wr) begin
            pending <= 1'b1;
        end else if (xfer) begin
            pending <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= '0;
        end else if (xfer) begin
            active <= staged_q;
        end
    end

endmodule

// File: rtl/evt_match.sv
`timescale 1ns/1ps
module evt_match #(
    parameter int CNT_W = 32
) (
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] cmp,
    input  logic             wrap_mode,
    output logic             reached
);

    logic [CNT_W-1:0] delta;

    always_comb begin
        delta = count - cmp;
        if (wrap_mode) begin
            reached = !delta[CNT_W-1];
        end else begin
            reached = (delta == '0);
        end
    end

endmodule

// File: rtl/evt_timer.sv
`timescale 1ns/1ps
module evt_timer #(
    parameter int CNT_W      = 32,
    parameter int XFER_TICKS = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [1:0]       bus_addr,
    input  logic             bus_wen,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             irq
);
    import evt_pkg::*;

    reg_sel_e         sel;
    ctrl_t            ctrl_q;
    logic             ctl_en;
    logic             ctl_wrap;
    logic             evt_q;
    logic             wr_cmp;
    logic             wr_ctrl;
    logic             wr_stat;
    logic             adv;
    logic             reached;
    logic             hit;
    logic             pend;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] act_cmp;

    assign sel      = reg_sel_e'(bus_addr);
    assign wr_cmp   = bus_wen && (sel == SEL_CMP);
    assign wr_ctrl  = bus_wen && (sel == SEL_CTRL);
    assign wr_stat  = bus_wen && (sel == SEL_STATUS);
    assign ctl_en   = ctrl_q.en;
    assign ctl_wrap = ctrl_q.wrap;
    assign adv      = tick && ctl_en;
    assign hit      = adv && reached;

    evt_counter #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst   (rst),
        .adv   (adv),
        .count (cnt_q)
    );

    evt_cmp_stage #(.CNT_W(CNT_W), .XFER_TICKS(XFER_TICKS)) u_stage (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr_cmp),
        .wdata   (bus_wdata),
        .tick    (tick),
        .active  (act_cmp),
        .pending (pend)
    );

    evt_match #(.CNT_W(CNT_W)) u_match (
        .count     (cnt_q),
        .cmp       (act_cmp),
        .wrap_mode (ctl_wrap),
        .reached   (reached)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= ctrl_decode(bus_wdata[1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q <= 1'b0;
        end else if (hit) begin
            evt_q <= 1'b1;
        end else if (wr_stat && bus_wdata[STAT_EVT_BIT]) begin
            evt_q <= 1'b0;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (sel)
            SEL_COUNT:  bus_rdata = cnt_q;
            SEL_CMP:    bus_rdata = act_cmp;
            SEL_CTRL: begin
                bus_rdata[CTRL_EN_BIT]   = ctrl_q.en;
                bus_rdata[CTRL_WRAP_BIT] = ctrl_q.wrap;
            end
            SEL_STATUS: begin
                bus_rdata[STAT_EVT_BIT]  = evt_q;
                bus_rdata[STAT_PEND_BIT] = pend;
            end
            default:    bus_rdata = '0;
        endcase
    end

    assign irq = evt_q && ctl_en;

endmodule

// File: rtl/evt_timer_chk.sv
`timescale 1ns/1ps
module evt_timer_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic [1:0]       bus_addr,
    input logic             bus_wen,
    input logic [CNT_W-1:0] bus_wdata,
    input logic             irq,
    input logic             ctl_en,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] act_cmp,
    input logic             pend,
    input logic             evt_q
);

    logic clr_wr;
    assign clr_wr = bus_wen && (bus_addr == 2'd3) && bus_wdata[0];

    // R1
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && ctl_en) |=> (cnt_q == $past(cnt_q) + 1'b1));

    // R10
    cnt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(tick && ctl_en) |=> $stable(cnt_q));

    // R3
    act_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(act_cmp));

    // R4
    pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wen && bus_addr == 2'd1) |=> pend);

    // R7
    evt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_q && !clr_wr) |=> evt_q);

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (evt_q && ctl_en));

endmodule

bind evt_timer evt_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .bus_addr  (bus_addr),
    .bus_wen   (bus_wen),
    .bus_wdata (bus_wdata),
    .irq       (irq),
    .ctl_en    (ctl_en),
    .cnt_q     (cnt_q),
    .act_cmp   (act_cmp),
    .pend      (pend),
    .evt_q     (evt_q)
);

// File: tb/test_evt_timer.sv
`timescale 1ns/1ps
module test_evt_timer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [1:0]  m_addr = 2'd0;
    logic        m_wen = 1'b0;
    logic [31:0] m_wdata = '0;
    logic [31:0] m_rdata;
    logic        m_irq;
    logic [1:0]  n_addr = 2'd0;
    logic        n_wen = 1'b0;
    logic [7:0]  n_wdata = '0;
    logic [7:0]  n_rdata;
    logic        n_irq;

    int n_tot = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    evt_timer #(.CNT_W(32), .XFER_TICKS(2)) i_evt_timer (
        .clk(clk), .rst(rst), .tick(tick), .bus_addr(m_addr), .bus_wen(m_wen),
        .bus_wdata(m_wdata), .bus_rdata(m_rdata), .irq(m_irq)
    );

    evt_timer #(.CNT_W(8), .XFER_TICKS(1)) i_evt_timer_narrow (
        .clk(clk), .rst(rst), .tick(tick), .bus_addr(n_addr), .bus_wen(n_wen),
        .bus_wdata(n_wdata), .bus_rdata(n_rdata), .irq(n_irq)
    );

    // {wrap_mode, start, compare, ticks until event}, 8-bit instance
    localparam logic [25:0] VEC [8] = '{
        {1'b0, 8'd10,  8'd20,  9'd11},
        {1'b0, 8'd10,  8'd10,  9'd1},
        {1'b0, 8'd10,  8'd5,   9'd252},
        {1'b1, 8'd10,  8'd5,   9'd1},
        {1'b1, 8'd10,  8'd20,  9'd11},
        {1'b1, 8'd250, 8'd4,   9'd11},
        {1'b0, 8'd250, 8'd4,   9'd11},
        {1'b1, 8'd4,   8'd250, 9'd1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tot++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(posedge clk); #1;
            tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(posedge clk); #1;
        end
    endtask

    task automatic m_wr(input logic [1:0] a, input logic [31:0] d, input logic t);
        m_addr = a; m_wdata = d; m_wen = 1'b1; tick = t;
        @(posedge clk); #1;
        m_wen = 1'b0; tick = 1'b0;
    endtask

    task automatic m_rd(input logic [1:0] a, output logic [31:0] d);
        m_addr = a;
        #1;
        d = m_rdata;
    endtask

    task automatic n_wr(input logic [1:0] a, input logic [7:0] d);
        n_addr = a; n_wdata = d; n_wen = 1'b1;
        @(posedge clk); #1;
        n_wen = 1'b0;
    endtask

    task automatic n_rd(input logic [1:0] a, output logic [7:0] d);
        n_addr = a;
        #1;
        d = n_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        n_tot++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        logic [7:0]  nr;
        int          cnt;

        do_reset();

        // match function over the vector table (R5, R6, R1)
        for (int v = 0; v < 8; v++) begin
            logic       mode;
            logic [7:0] start;
            logic [7:0] cmpv;
            int         expn;
            mode  = VEC[v][25];
            start = VEC[v][24:17];
            cmpv  = VEC[v][16:9];
            expn  = int'(VEC[v][8:0]);
            do_reset();
            n_wr(2'd2, 8'h01);
            ticks(int'(start));
            n_rd(2'd0, nr);
            chk("R1 count after advance", {24'd0, nr}, {24'd0, start});
            n_wr(2'd2, 8'h00);
            n_wr(2'd1, cmpv);
            ticks(1);
            n_wr(2'd3, 8'h01);
            n_wr(2'd2, {6'd0, mode, 1'b1});
            cnt = 0;
            nr  = '0;
            while (cnt < 300 && nr[0] == 1'b0) begin
                ticks(1);
                cnt++;
                n_rd(2'd3, nr);
            end
            if (mode) chk("R6 ticks to event", cnt, expn);
            else      chk("R5 ticks to event", cnt, expn);
        end

        // R1 wrap of the narrow counter
        do_reset();
        n_wr(2'd2, 8'h01);
        ticks(255);
        n_rd(2'd0, nr);
        chk("R1 all-ones", {24'd0, nr}, 32'hff);
        ticks(1);
        n_rd(2'd0, nr);
        chk("R1 wrap to zero", {24'd0, nr}, 32'h0);

        // R3 single-tick latency on narrow instance
        n_wr(2'd1, 8'h33);
        n_rd(2'd1, nr);
        chk("R3 narrow stale read", {24'd0, nr}, 32'h0);
        ticks(1);
        n_rd(2'd1, nr);
        chk("R3 narrow after one tick", {24'd0, nr}, 32'h33);

        // directed tests on 32-bit instance
        do_reset();
        for (int a = 0; a < 4; a++) begin
            m_rd(a[1:0], r);
            chk("R9 reset register", r, 32'h0);
        end
        chk("R9 reset irq", {31'd0, m_irq}, 32'h0);

        m_wr(2'd1, 32'd100, 1'b0);
        m_rd(2'd1, r);
        chk("R3 read after write stale", r, 32'h0);
        m_rd(2'd3, r);
        chk("R4 pending set", r, 32'h2);
        ticks(1);
        m_rd(2'd1, r);
        chk("R3 still stale after one tick", r, 32'h0);
        m_rd(2'd3, r);
        chk("R4 pending after one tick", r, 32'h2);
        ticks(1);
        m_rd(2'd1, r);
        chk("R3 active after two ticks", r, 32'd100);
        m_rd(2'd3, r);
        chk("R4 pending cleared", r, 32'h0);
        m_rd(2'd0, r);
        chk("R10 counter frozen while disabled", r, 32'h0);

        m_wr(2'd2, 32'h1, 1'b0);
        m_rd(2'd2, r);
        chk("R2 control readback", r, 32'h1);
        m_wr(2'd0, 32'd55, 1'b0);
        m_rd(2'd0, r);
        chk("R2 counter write ignored", r, 32'h0);
        idle(5);
        m_rd(2'd0, r);
        chk("R1 hold without tick", r, 32'h0);

        ticks(100);
        m_rd(2'd3, r);
        chk("R5 no event before hit tick", r, 32'h0);
        ticks(1);
        m_rd(2'd3, r);
        chk("R5 event on equal tick", r, 32'h1);
        chk("R8 irq with enable", {31'd0, m_irq}, 32'h1);
        m_rd(2'd0, r);
        chk("R1 counter value", r, 32'd101);

        m_wr(2'd3, 32'h0, 1'b0);
        m_rd(2'd3, r);
        chk("R7 write zero keeps event", r, 32'h1);
        m_wr(2'd2, 32'h0, 1'b0);
        chk("R8 irq masked by enable", {31'd0, m_irq}, 32'h0);
        m_rd(2'd3, r);
        chk("R7 event kept while disabled", r, 32'h1);
        m_wr(2'd3, 32'h1, 1'b0);
        m_rd(2'd3, r);
        chk("R7 write one clears", r, 32'h0);

        m_wr(2'd2, 32'h3, 1'b0);
        m_rd(2'd2, r);
        chk("R2 control wrap readback", r, 32'h3);
        ticks(1);
        m_rd(2'd3, r);
        chk("R6 passed value fires", r, 32'h1);
        m_wr(2'd3, 32'h1, 1'b1);
        m_rd(2'd3, r);
        chk("R7 set wins over clear", r, 32'h1);
        m_wr(2'd3, 32'h1, 1'b0);
        m_rd(2'd3, r);
        chk("R7 clear without tick", r, 32'h0);
        ticks(1);
        m_rd(2'd3, r);
        chk("R6 re-fires while reached", r, 32'h1);

        do_reset();
        m_rd(2'd0, r);
        chk("R9 counter cleared", r, 32'h0);
        m_rd(2'd1, r);
        chk("R9 compare cleared", r, 32'h0);
        m_rd(2'd2, r);
        chk("R9 control cleared", r, 32'h0);
        m_rd(2'd3, r);
        chk("R9 status cleared", r, 32'h0);

        m_wr(2'd1, 32'd7, 1'b0);
        ticks(3);
        m_rd(2'd3, r);
        chk("R10 no event while disabled", r, 32'h0);

        $display("test done: total=%0d bad=%0d", n_tot, n_bad);
        $finish;
    end

endmodule